// File: doc/BRIEF.md
# MMC Command/Response Sequencer

This block runs one host command on the single-bit MMC command line and collects the card's reply. Software-style inputs give the command index, a 32-bit argument, a response-type code, an open-drain flag and a latency extension. A one-clock `go` pulse requests the command. The sequencer builds a 48-bit frame that carries a CRC7. It shifts the frame out one bit per card-clock tick, then releases the line for a turnaround window. After that it watches for the card's start bit, shifts in a short or long response, checks that response's CRC7 and reports the outcome.

All sequencing advances on a `tick` enable that marks the card-clock edges, so the block shares the system clock with the rest of the chip. The block does not drive pads. It provides the serial bit, a drive-enable and a flag that tells the pad logic to use open-drain rather than push-pull drive for the current command. The data path, multi-block transfers and card state tracking belong to other blocks.

Top module: `mmc_cmd_seq`

## Requirements
- R1: After reset, `cmd_oe`, `busy`, `done`, `timeout` and `crc_err` are 0, `cmd_out` is 1 and `rsp_data` is all zeros.
- R2: A `go` pulse while `enable` is 0 is dropped. No command starts, and none starts later when `enable` is raised.
- R3: The command frame is 48 bits, sent MSB first, one bit per tick, with `cmd_oe` high for exactly those 48 ticks. Bit 47 is 0, bit 46 is 1, bits 45:40 hold the index and bits 39:8 the argument. Bits 7:1 hold a CRC7 (polynomial x^7+x^3+1, register cleared to zero) computed over bits 47:8. Bit 0 is 1.
- R4: `od_mode` equals the open-drain flag sampled with the accepted `go`. It holds steady while the command is busy.
- R5: With type code 0 there is no response. `busy` falls and `done` rises one clock after the tick that ends the end bit, with no flags set.
- R6: After the end bit, the line stays released for 5 + `max_lat` ticks, and `cmd_in` is ignored during them. A low level in that window does not start a capture.
- R7: After the turnaround window, the block samples `cmd_in` on up to 64 ticks. A 0 on any of them is the start bit. If all 64 samples are 1, `timeout` and `done` are set and `rsp_data` stays zero.
- R8: Type codes 1 and 3 capture a 48-bit response into `rsp_data[47:0]`, first received bit (the start bit) in bit 47 and upper bits zero.
- R9: Type code 2 captures a 136-bit response into `rsp_data[135:0]`, first received bit in bit 135.
- R10: For a 48-bit response, CRC7 over bits 47:8 must equal bits 7:1. For a 136-bit response, CRC7 over bits 127:8 must equal bits 7:1. A mismatch sets `crc_err` together with `done`, and `crc_err` is never set together with `timeout`.
- R11: `busy` is high from acceptance until completion, and `done` is never high while `busy` is high. `done`, `timeout` and `crc_err` hold until the next command is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Card-clock enable; one sequencer step per pulse |
| enable | input | 1 | Block enable; commands are accepted only while high |
| go | input | 1 | Command request pulse |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 2 | 0 none, 2 long (136), 1 or 3 short (48) |
| open_drain | input | 1 | Requests open-drain drive for this command |
| max_lat | input | 4 | Extra turnaround ticks beyond the minimum of 5 |
| cmd_in | input | 1 | Sampled command line level |
| cmd_out | output | 1 | Serial bit to drive (1 when not driving) |
| cmd_oe | output | 1 | Drive enable for the command line |
| od_mode | output | 1 | Pad mode: 1 open-drain, 0 push-pull |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command completed |
| timeout | output | 1 | No start bit seen within the window |
| crc_err | output | 1 | Response CRC7 mismatch |
| rsp_data | output | 136 | Captured response bits |

## Verification
The embedded properties check on every cycle that the drive enable is only high in the send phase, that the turnaround and start-bit counters stay within their windows, that a disabled idle block stays idle, that the pad mode is stable during a command and that status flags do not conflict. Only the bench scenarios can show the exact frame bit order and CRC, that the release lasts the right number of ticks for a given latency, and that a low level in turnaround is ignored. They also cover the 63-tick and 64-tick edges of the start-bit window and the correct capture and CRC verdict for short, long and corrupted responses.

// File: rtl/mmc_cmd_pkg.sv
`timescale 1ns/1ps
package mmc_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_TURN,
    ST_WAIT,
    ST_RECV,
    ST_FIN
  } seq_state_t;

  localparam logic [6:0] CRC7_POLY = 7'h09;
  localparam int CRC_SPAN = 120;

  // One serial step of the seven-bit check register.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
  endfunction

  // Folds the low nbits of d, highest bit first.
  function automatic logic [6:0] crc7_vec(input logic [CRC_SPAN-1:0] d, input int nbits);
    logic [6:0] c;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) begin
      if (i < nbits) c = crc7_step(c, d[i]);
    end
    return c;
  endfunction

endpackage

// File: rtl/mmc_tick_timer.sv
`timescale 1ns/1ps
module mmc_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (inc)     count <= count + 1'b1;
  end
endmodule

// File: rtl/mmc_cmd_tx.sv
`timescale 1ns/1ps
module mmc_cmd_tx
  import mmc_cmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic             shift_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             bit_out,
  output logic             last
);
  localparam int PAY_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = PAY_W + 8;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [PAY_W-1:0]    payload;
  logic [CRC_SPAN-1:0] pay_ext;
  logic [6:0]          pay_crc;
  logic [FRAME_W-1:0]  sreg;
  logic [CNT_W-1:0]    cnt;

  assign payload = {2'b01, idx, arg};
  assign pay_ext = CRC_SPAN'(payload);
  assign pay_crc = crc7_vec(pay_ext, PAY_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '1;
      cnt  <= '0;
    end else if (load) begin
      sreg <= {payload, pay_crc, 1'b1};
      cnt  <= '0;
    end else if (tick && shift_en && !last) begin
      sreg <= {sreg[FRAME_W-2:0], 1'b1};
      cnt  <= cnt + 1'b1;
    end
  end

  assign bit_out = sreg[FRAME_W-1];
  assign last    = (cnt == CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/mmc_rsp_rx.sv
`timescale 1ns/1ps
module mmc_rsp_rx
  import mmc_cmd_pkg::*;
#(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                shift,
  input  logic                bit_in,
  input  logic                long_sel,
  output logic [LONG_LEN-1:0] data,
  output logic                crc_ok
);
  localparam int SHORT_CRC_N = SHORT_LEN - 8;
  localparam int LONG_CRC_HI = LONG_LEN - 9;
  localparam int LONG_CRC_N  = LONG_CRC_HI - 7;

  logic [CRC_SPAN-1:0] short_vec, long_vec;
  logic [6:0]          short_crc, long_crc;

  always_ff @(posedge clk) begin
    if (rst || clear) data <= '0;
    else if (shift)   data <= {data[LONG_LEN-2:0], bit_in};
  end

  assign short_vec = CRC_SPAN'(data[SHORT_LEN-1:8]);
  assign long_vec  = CRC_SPAN'(data[LONG_CRC_HI:8]);
  assign short_crc = crc7_vec(short_vec, SHORT_CRC_N);
  assign long_crc  = crc7_vec(long_vec, LONG_CRC_N);
  assign crc_ok    = long_sel ? (long_crc == data[7:1]) : (short_crc == data[7:1]);
endmodule

// File: rtl/mmc_cmd_seq.sv
`timescale 1ns/1ps
module mmc_cmd_seq
  import mmc_cmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int LAT_W     = 4,
  parameter int NID_MIN   = 5,
  parameter int SB_WINDOW = 64,
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                enable,
  input  logic                go,
  input  logic [IDX_W-1:0]    cmd_index,
  input  logic [ARG_W-1:0]    cmd_arg,
  input  logic [1:0]          rsp_type,
  input  logic                open_drain,
  input  logic [LAT_W-1:0]    max_lat,
  input  logic                cmd_in,
  output logic                cmd_out,
  output logic                cmd_oe,
  output logic                od_mode,
  output logic                busy,
  output logic                done,
  output logic                timeout,
  output logic                crc_err,
  output logic [LONG_LEN-1:0] rsp_data
);
  localparam int TURN_MAX = NID_MIN + (1 << LAT_W) - 1;
  localparam int MAX_A    = (TURN_MAX > SB_WINDOW) ? TURN_MAX : SB_WINDOW;
  localparam int CNT_MAX  = (MAX_A > LONG_LEN) ? MAX_A : LONG_LEN;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  seq_state_t       state, nxt;
  logic             req, sh_od;
  logic [IDX_W-1:0] sh_idx;
  logic [ARG_W-1:0] sh_arg;
  logic [1:0]       sh_type;
  logic [LAT_W-1:0] sh_lat;

  logic             start, tx_bit, tx_last, rx_crc_ok, long_sel, no_rsp;
  logic             tmr_clr, tmr_inc, rx_clr, rx_shift, sb_expire;
  logic [CNT_W-1:0] tcount, turn_len, rsp_last;

  assign start    = tick && req && enable && (state == ST_IDLE);
  assign long_sel = (sh_type == 2'd2);
  assign no_rsp   = (sh_type == 2'd0);
  assign turn_len = CNT_W'(NID_MIN) + CNT_W'(sh_lat);
  assign rsp_last = long_sel ? CNT_W'(LONG_LEN - 2) : CNT_W'(SHORT_LEN - 2);
  assign sb_expire = (state == ST_WAIT) && tick && cmd_in &&
                     (tcount == CNT_W'(SB_WINDOW - 1));

  mmc_cmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load(start),
    .shift_en(state == ST_SEND), .idx(sh_idx), .arg(sh_arg),
    .bit_out(tx_bit), .last(tx_last)
  );

  mmc_tick_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clear(tmr_clr), .inc(tmr_inc), .count(tcount)
  );

  mmc_rsp_rx #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_rx (
    .clk(clk), .rst(rst), .clear(rx_clr), .shift(rx_shift), .bit_in(cmd_in),
    .long_sel(long_sel), .data(rsp_data), .crc_ok(rx_crc_ok)
  );

  always_comb begin
    nxt      = state;
    tmr_clr  = 1'b0;
    tmr_inc  = 1'b0;
    rx_clr   = 1'b0;
    rx_shift = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        nxt    = ST_SEND;
        rx_clr = 1'b1;
      end
      ST_SEND: if (tick && tx_last) begin
        tmr_clr = 1'b1;
        nxt     = no_rsp ? ST_FIN : ST_TURN;
      end
      ST_TURN: if (tick) begin
        if (tcount == turn_len - 1'b1) begin
          nxt     = ST_WAIT;
          tmr_clr = 1'b1;
        end else begin
          tmr_inc = 1'b1;
        end
      end
      ST_WAIT: if (tick) begin
        if (!cmd_in) begin
          rx_shift = 1'b1;
          tmr_clr  = 1'b1;
          nxt      = ST_RECV;
        end else if (tcount == CNT_W'(SB_WINDOW - 1)) begin
          nxt = ST_FIN;
        end else begin
          tmr_inc = 1'b1;
        end
      end
      ST_RECV: if (tick) begin
        rx_shift = 1'b1;
        if (tcount == rsp_last) nxt = ST_FIN;
        else                    tmr_inc = 1'b1;
      end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      req     <= 1'b0;
      sh_idx  <= '0;
      sh_arg  <= '0;
      sh_type <= '0;
      sh_lat  <= '0;
      sh_od   <= 1'b0;
      od_mode <= 1'b0;
      cmd_oe  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
      crc_err <= 1'b0;
    end else begin
      state <= nxt;
      if (!enable) begin
        req <= 1'b0;
      end else if (state == ST_IDLE && go && !req) begin
        req     <= 1'b1;
        sh_idx  <= cmd_index;
        sh_arg  <= cmd_arg;
        sh_type <= rsp_type;
        sh_lat  <= max_lat;
        sh_od   <= open_drain;
      end
      if (start) begin
        req     <= 1'b0;
        busy    <= 1'b1;
        done    <= 1'b0;
        timeout <= 1'b0;
        crc_err <= 1'b0;
        cmd_oe  <= 1'b1;
        od_mode <= sh_od;
      end
      if (state == ST_SEND && tick && tx_last) cmd_oe <= 1'b0;
      if (sb_expire) timeout <= 1'b1;
      if (state == ST_FIN) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (!no_rsp && !timeout && !rx_crc_ok) crc_err <= 1'b1;
      end
    end
  end

  assign cmd_out = cmd_oe ? tx_bit : 1'b1;

  assert_idle_when_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !enable) |=> (state == ST_IDLE));
  assert_drive_only_in_send_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> (state == ST_SEND));
  assert_mode_held_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(od_mode));
  assert_turn_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN) |-> (tcount < turn_len && !cmd_oe));
  assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (tcount < CNT_W'(SB_WINDOW)));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(timeout && crc_err));
  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/mmc_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module mmc_cmd_seq_tb_top;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, enable = 1'b0, go = 1'b0;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic [1:0]   rsp_type = '0;
  logic         open_drain = 1'b0, cmd_in = 1'b1;
  logic [3:0]   max_lat = '0;
  logic         cmd_out, cmd_oe, od_mode, busy, done, timeout, crc_err;
  logic [135:0] rsp_data;
  logic [1:0]   div = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct packed {
    logic to; logic ce; logic od; logic [135:0] data;
  } exp_t;
  exp_t exp_q[$];

  mmc_cmd_seq dut_i (
    .clk(clk), .rst(rst), .tick(tick), .enable(enable), .go(go),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_type(rsp_type),
    .open_drain(open_drain), .max_lat(max_lat), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .od_mode(od_mode), .busy(busy),
    .done(done), .timeout(timeout), .crc_err(crc_err), .rsp_data(rsp_data)
  );

  always #2 clk = ~clk;
  always @(negedge clk) begin
    div  <= div + 1'b1;
    tick <= (div == 2'd3);
  end

  task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] tb_crc(input logic [119:0] v, input int n);
    logic [6:0] r;
    r = '0;
    for (int k = n - 1; k >= 0; k--) begin
      logic fb;
      fb = v[k] ^ r[6];
      r = r << 1;
      r[0] = fb;
      r[3] = r[3] ^ fb;
    end
    return r;
  endfunction

  task automatic next_tick;
    do @(posedge clk); while (!tick);
    #1;
  endtask

  // Monitor: pops one expected outcome whenever a command completes.
  logic mon_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && mon_prev && !busy) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected completion", 136'(1), 136'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R11 done on completion", 136'(done), 136'(1));
        check("R7 timeout flag", 136'(timeout), 136'(e.to));
        check("R10 crc flag", 136'(crc_err), 136'(e.ce));
        check("R4 mode after command", 136'(od_mode), 136'(e.od));
        check("R8 R9 response data", rsp_data, e.data);
      end
    end
    mon_prev = busy;
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                         input logic od, input logic [3:0] lat, input int delay,
                         input bit bad, input bit glitch);
    logic [47:0]  frame, got;
    logic [39:0]  pay;
    logic [135:0] resp;
    logic [119:0] body;
    logic [6:0]   c;
    exp_t e;
    int len, g;
    pay   = {2'b01, idx, arg};
    frame = {pay, tb_crc(120'(pay), 40), 1'b1};
    len   = (rt == 2'd2) ? 136 : 48;
    if (rt == 2'd2) begin
      body = {arg, ~arg, arg ^ 32'h1234_5678, arg[23:0]};
      c = tb_crc(body, 120) ^ (bad ? 7'h01 : 7'h00);
      resp = {2'b00, 6'h3F, body, c, 1'b1};
    end else begin
      pay = {2'b00, idx, arg ^ 32'hA5A5_0F0F};
      c = tb_crc(120'(pay), 40) ^ (bad ? 7'h01 : 7'h00);
      resp = 136'({pay, c, 1'b1});
    end
    e.od = od;
    e.to = (rt != 2'd0) && (delay >= 64);
    e.ce = (rt != 2'd0) && (delay < 64) && bad;
    e.data = (rt == 2'd0 || delay >= 64) ? '0 : resp;
    exp_q.push_back(e);

    cmd_index = idx; cmd_arg = arg; rsp_type = rt; open_drain = od; max_lat = lat;
    @(posedge clk); #1 go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
    g = 0;
    while (!cmd_oe && g < 20) begin next_tick; g++; end
    check("R11 busy during command", 136'(busy), 136'(1));
    check("R4 mode flag", 136'(od_mode), 136'(od));
    for (int i = 0; i < 48; i++) begin
      got[47-i] = cmd_out;
      next_tick;
    end
    check("R3 frame bits", 136'(got), 136'(frame));
    check("R3 release after end bit", 136'(cmd_oe), 136'(0));
    if (rt == 2'd0) begin
      @(posedge clk); #1;
      check("R5 done without response", 136'({busy, done, timeout}), 136'(3'b010));
      return;
    end
    cmd_in = glitch ? 1'b0 : 1'b1;
    for (int k = 0; k < 5 + int'(lat); k++) next_tick;
    cmd_in = 1'b1;
    check("R6 line released in turnaround", 136'(cmd_oe), 136'(0));
    for (int k = 0; k < delay && k < 64; k++) next_tick;
    if (delay < 64) begin
      for (int b = len - 1; b >= 0; b--) begin
        cmd_in = resp[b];
        next_tick;
      end
      cmd_in = 1'b1;
    end
    g = 0;
    while (busy && g < 2000) begin @(posedge clk); g++; end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check("R1 reset outputs", 136'({cmd_oe, busy, done, timeout, crc_err, cmd_out}),
          136'(6'b000001));
    check("R1 reset data", rsp_data, '0);
    // R2 go while disabled is dropped
    @(posedge clk); #1 go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
    repeat (20) next_tick;
    check("R2 disabled go ignored", 136'({busy, cmd_oe}), 136'(0));
    enable = 1'b1;
    repeat (20) next_tick;
    check("R2 no late start after enable", 136'({busy, cmd_oe}), 136'(0));
    // R9 R4 long response, open drain, minimum turnaround
    run_cmd(6'd2, 32'h0000_0000, 2'd2, 1'b1, 4'd0, 0, 1'b0, 1'b0);
    // R5 no response
    run_cmd(6'd0, 32'hDEAD_BEEF, 2'd0, 1'b1, 4'd0, 0, 1'b0, 1'b0);
    // R8 short response, push-pull, extended turnaround
    run_cmd(6'd17, 32'h1234_ABCD, 2'd1, 1'b0, 4'd3, 10, 1'b0, 1'b0);
    // R10 short response with bad CRC
    run_cmd(6'd13, 32'h0F0F_0001, 2'd1, 1'b0, 4'd0, 2, 1'b1, 1'b0);
    // R10 long response with bad CRC
    run_cmd(6'd9, 32'hCAFE_0042, 2'd2, 1'b0, 4'd1, 4, 1'b1, 1'b0);
    // R7 start bit on the last sample of the window is accepted
    run_cmd(6'd7, 32'h8000_0001, 2'd1, 1'b0, 4'd0, 63, 1'b0, 1'b0);
    // R7 no start bit within 64 samples times out
    run_cmd(6'd3, 32'h0000_00FF, 2'd1, 1'b1, 4'd2, 64, 1'b0, 1'b0);
    // R6 low level during turnaround ignored, R11 flags cleared by new command
    run_cmd(6'd55, 32'h5555_AAAA, 2'd1, 1'b0, 4'd15, 5, 1'b0, 1'b1);
    // R8 code 3 behaves as a short response
    run_cmd(6'd63, 32'hFFFF_FFFF, 2'd3, 1'b1, 4'd0, 1, 1'b0, 1'b0);
    repeat (10) @(posedge clk);
    check("R11 scoreboard drained", 136'(exp_q.size()), 136'(0));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule